// File: doc/BRIEF.md
# Dual Down-Counting Event Timer

This peripheral holds two independent 32-bit counters that count down. Each one can run as a one-shot delay or as a periodic tick source that restarts from its reload register. Every counter decrements on a tick, and its tick source can be chosen. One source is an external fixed-rate enable pin. The other is the system clock divided by 2^N, where N comes from a small per-timer field. When a counter expires it sets a sticky flag in a shared status register. The interrupt line for that timer is asserted while both the flag and the timer's enable bit are set.

Software reaches the block through a single-cycle register port. Writes are taken on the clock edge where `bus_we` is high, and read data follows `bus_addr` combinationally. Software can turn a reading of a free-running timer into a rising time base by inverting it. For that reason a counter that reaches zero with a reload of all-ones wraps to all-ones cleanly. A counter that was stopped keeps its value. An expired one-shot stays at zero until software writes a new value.

Top module: `dual_down_timer`

## Requirements
- R1: Register offsets are control 0x00, status 0x04, reload A 0x10, count A 0x14, reload B 0x18 and count B 0x1C. In the control register, timer A uses bit 0 (run), bit 1 (auto-reload), bit 11 (fixed-tick select) and bits 21:19 (prescale exponent). Timer B uses bits 2, 3, 12 and 24:22 for the same four controls. Unused control bits read as 0. The reload and count registers read back as written.
- R2: An enabled counter with a nonzero value decrements by one on each tick. On the first tick after it reaches 0 it sets its flag. A value of V written and then run with a tick every cycle raises the flag V+1 cycles after the enabling write.
- R3: With auto-reload clear, expiry fires once. The count then stays at 0, and no further flag is raised until a new value is written.
- R4: With auto-reload set, expiry loads the reload register, so reload value R gives a period of R+1 ticks.
- R5: A count of 0 with reload 0xFFFFFFFF wraps to 0xFFFFFFFF on expiry and then keeps decrementing.
- R6: Status bit 0 is timer A's flag and bit 8 is timer B's flag. A write to the status register clears each flag whose bit is written 0 and leaves each flag whose bit is written 1 unchanged.
- R7: `irq[i]` is the AND of flag i and the run bit of timer i.
- R8: Clearing a run bit stops the count and keeps its current value.
- R9: With fixed-tick select set, the counter advances only in cycles where `fixed_tick` is high.
- R10: With fixed-tick select clear and exponent N, ticks come once every 2^N system clocks.
- R11: A bus write to a count register in a cycle that also has a tick replaces the count, and that tick raises no flag.
- R12: An expiry in the same cycle as a status write that clears its flag leaves the flag set.
- R13: After reset every register reads 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| fixed_tick | input | 1 | Fixed-rate tick enable, one cycle wide per tick |
| irq | output | 2 | Per-timer interrupt, bit 0 for timer A |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a software count write and a counter tick. The second pair is a flag-clearing status write and an expiry. The bench provokes both by arming a timer at zero with the fixed-tick source. It then raises `fixed_tick` in the same cycle as the register write. For the count write, the written value must appear and the flag must stay clear. For the status write, the flag must stay set. The prescaler is judged by the interval between count changes rather than by absolute phase, because its divider runs free from reset.

// File: rtl/dual_timer_pkg.sv
// Package: register offsets and control-field positions shared by the
// dual timer. Assumes byte addressing with 32-bit registers.
package dual_timer_pkg;
    localparam int unsigned NUM_TMR = 2;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_STATUS = 8'h04;
    localparam logic [7:0] OFS_RLD_A  = 8'h10;
    localparam logic [7:0] OFS_CNT_A  = 8'h14;
    localparam logic [7:0] OFS_RLD_B  = 8'h18;
    localparam logic [7:0] OFS_CNT_B  = 8'h1C;

    // Control bit positions per timer (index 0 = timer A, 1 = timer B).
    function automatic int unsigned run_bit(input int unsigned t);
        return 2 * t;
    endfunction
    function automatic int unsigned rld_bit(input int unsigned t);
        return 2 * t + 1;
    endfunction
    function automatic int unsigned fix_bit(input int unsigned t);
        return 11 + t;
    endfunction
    function automatic int unsigned div_lsb(input int unsigned t);
        return 19 + 3 * t;
    endfunction
    // Status flag position per timer.
    function automatic int unsigned flag_bit(input int unsigned t);
        return 8 * t;
    endfunction
endpackage

// File: rtl/dt_prescaler.sv
// Module: dt_prescaler
// Free-running divider shared by both timers. For each timer it issues a
// one-cycle tick every 2^N clocks, where N is that timer's exponent.
// Assumes the exponent is at most 2^DIV_W - 1. The tick phase is set by reset.
module dt_prescaler #(
    parameter int unsigned DIV_W = 3,
    parameter int unsigned NT    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NT*DIV_W-1:0]   exp_n,
    output logic [NT-1:0]         tick
);
    localparam int unsigned PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre_q;

    // Purpose: advance the shared divider every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + PRE_W'(1);
    end

    for (genvar t = 0; t < NT; t++) begin : g_tick
        logic [PRE_W-1:0] low_mask;
        // Purpose: mask of divider bits that must all be one for a tick.
        always_comb begin
            low_mask = PRE_W'((PRE_W+1)'(1) << exp_n[t*DIV_W +: DIV_W]) - PRE_W'(1);
            tick[t]  = &(pre_q | ~low_mask);
        end
    end
endmodule

// File: rtl/dt_counter.sv
// Module: dt_counter
// One down counter. A software load has priority over a tick. Expiry is a
// tick seen while the count is 0 and the counter is armed. After expiry the
// counter reloads if auto-reload is on; otherwise it disarms and holds 0.
// Assumes the caller qualifies 'tick' with the chosen tick source.
module dt_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             auto_rld,
    input  logic             tick,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] rld_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] count_q;
    logic             armed_q;
    logic             step;

    // Purpose: qualify a tick that may move the counter this cycle.
    always_comb begin
        step   = run && tick && armed_q && !load_we;
        expire = step && (count_q == '0);
        count  = count_q;
    end

    // Purpose: count state and the one-shot arm bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            armed_q <= 1'b0;
        end else if (load_we) begin
            count_q <= load_val;
            armed_q <= 1'b1;
        end else if (expire) begin
            count_q <= auto_rld ? rld_val : '0;
            armed_q <= auto_rld;
        end else if (step) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> count_q == $past(load_val));
    p_frozen_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_we) |=> $stable(count_q));
    p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && armed_q && !load_we && count_q != '0) |=> count_q == $past(count_q) - CNT_W'(1));
    p_oneshot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !load_we) |=> $stable(count_q));
endmodule

// File: rtl/dual_down_timer.sv
// Module: dual_down_timer (top)
// Two reloadable down counters behind a simple register port. It decodes
// the registers, selects each tick source and keeps the sticky flags and the
// interrupts. Assumes a single-cycle write strobe and a combinational read.
module dual_down_timer #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DIV_W  = 3,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              fixed_tick,
    output logic [1:0]        irq
);
    import dual_timer_pkg::*;

    localparam int unsigned NT = NUM_TMR;

    logic [31:0]          ctrl_q;
    logic [31:0]          ctrl_mask;
    logic [NT-1:0]        flag_q;
    logic [NT-1:0]        flag_keep;
    logic [NT-1:0]        expire;
    logic [NT-1:0]        pre_tick;
    logic [NT*DIV_W-1:0]  exp_n;
    logic [CNT_W-1:0]     rld_q [NT];
    logic [CNT_W-1:0]     cnt   [NT];
    logic                 wr_ctrl, wr_sts;
    logic [31:0]          sts_view;

    // Purpose: decode the writes to the control and status registers.
    always_comb begin
        wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_sts  = bus_we && (bus_addr == ADDR_W'(OFS_STATUS));
    end

    // Purpose: bits of the control register that hold storage.
    always_comb begin
        ctrl_mask = '0;
        for (int t = 0; t < NT; t++) begin
            ctrl_mask[run_bit(t)] = 1'b1;
            ctrl_mask[rld_bit(t)] = 1'b1;
            ctrl_mask[fix_bit(t)] = 1'b1;
            for (int b = 0; b < DIV_W; b++) ctrl_mask[div_lsb(t) + b] = 1'b1;
        end
    end

    // Purpose: control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata & ctrl_mask;
    end

    dt_prescaler #(.DIV_W(DIV_W), .NT(NT)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .exp_n (exp_n),
        .tick  (pre_tick)
    );

    for (genvar t = 0; t < NT; t++) begin : g_tmr
        localparam logic [7:0] RLD_OFS = (t == 0) ? OFS_RLD_A : OFS_RLD_B;
        localparam logic [7:0] CNT_OFS = (t == 0) ? OFS_CNT_A : OFS_CNT_B;
        logic wr_rld, wr_cnt, tick_sel, run;

        // Purpose: per-timer write decode, tick source and run bit.
        always_comb begin
            wr_rld   = bus_we && (bus_addr == ADDR_W'(RLD_OFS));
            wr_cnt   = bus_we && (bus_addr == ADDR_W'(CNT_OFS));
            run      = ctrl_q[run_bit(t)];
            tick_sel = ctrl_q[fix_bit(t)] ? fixed_tick : pre_tick[t];
            exp_n[t*DIV_W +: DIV_W] = ctrl_q[div_lsb(t) +: DIV_W];
            flag_keep[t] = wr_sts ? bus_wdata[flag_bit(t)] : 1'b1;
            irq[t]   = flag_q[t] && run;
        end

        // Purpose: reload register storage.
        always_ff @(posedge clk) begin
            if (!rst_n)      rld_q[t] <= '0;
            else if (wr_rld) rld_q[t] <= bus_wdata[CNT_W-1:0];
        end

        // Purpose: sticky flag; a set from expiry beats a clear from software.
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[t] <= 1'b0;
            else        flag_q[t] <= (flag_q[t] && flag_keep[t]) || expire[t];
        end

        dt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .auto_rld (ctrl_q[rld_bit(t)]),
            .tick     (tick_sel),
            .load_we  (wr_cnt),
            .load_val (bus_wdata[CNT_W-1:0]),
            .rld_val  (rld_q[t]),
            .count    (cnt[t]),
            .expire   (expire[t])
        );

        p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sts && !bus_wdata[flag_bit(t)] && !expire[t]) |=> !flag_q[t]);
        p_expiry_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
            expire[t] |=> flag_q[t]);
        p_ack_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sts && bus_wdata[flag_bit(t)] && flag_q[t]) |=> flag_q[t]);
    end

    // Purpose: status view with flags at their register positions.
    always_comb begin
        sts_view = '0;
        for (int t = 0; t < NT; t++) sts_view[flag_bit(t)] = flag_q[t];
    end

    // Purpose: combinational read multiplexer.
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_CTRL):   bus_rdata = ctrl_q;
            ADDR_W'(OFS_STATUS): bus_rdata = sts_view;
            ADDR_W'(OFS_RLD_A):  bus_rdata = 32'(rld_q[0]);
            ADDR_W'(OFS_CNT_A):  bus_rdata = 32'(cnt[0]);
            ADDR_W'(OFS_RLD_B):  bus_rdata = 32'(rld_q[1]);
            ADDR_W'(OFS_CNT_B):  bus_rdata = 32'(cnt[1]);
            default:             bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/dual_down_timer_tb_top.sv
// Directed bench for dual_down_timer: one task per scenario.
module dual_down_timer_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fixed_tick = 1'b0;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_down_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fixed_tick(fixed_tick), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        foreach (v[i]) ; // no-op
        rd(8'h00, v); chk("R13 ctrl", v, 0);
        rd(8'h04, v); chk("R13 status", v, 0);
        rd(8'h10, v); chk("R13 reload A", v, 0);
        rd(8'h14, v); chk("R13 count A", v, 0);
        rd(8'h18, v); chk("R13 reload B", v, 0);
        rd(8'h1C, v); chk("R13 count B", v, 0);
        chk("R13 irq", 32'(irq), 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R1 ctrl implemented bits", v, 32'h01F8_180F);
        wr(8'h00, 32'h0);
        wr(8'h10, 32'h1234_5678); wr(8'h18, 32'h9ABC_DEF0);
        wr(8'h14, 32'h0BAD_F00D); wr(8'h1C, 32'h0000_0042);
        rd(8'h10, v); chk("R1 reload A", v, 32'h1234_5678);
        rd(8'h18, v); chk("R1 reload B", v, 32'h9ABC_DEF0);
        rd(8'h14, v); chk("R1 count A", v, 32'h0BAD_F00D);
        rd(8'h1C, v); chk("R1 count B", v, 32'h0000_0042);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(8'h14, 32'd5);
        wr(8'h00, 32'h1);
        repeat (5) @(negedge clk);
        rd(8'h14, v); chk("R2 count at zero", v, 0);
        rd(8'h04, v); chk("R2 no flag before expiry", v, 0);
        @(negedge clk);
        rd(8'h04, v); chk("R2 flag after V+1 ticks", v, 32'h1);
        chk("R7 irq A raised", 32'(irq), 32'h1);
        repeat (4) @(negedge clk);
        rd(8'h14, v); chk("R3 one-shot holds zero", v, 0);
        wr(8'h04, 32'hFFFF_FFFE);
        repeat (10) @(negedge clk);
        rd(8'h04, v); chk("R3 no second expiry", v, 0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(8'h00, 32'h0);
        wr(8'h10, 32'd3); wr(8'h14, 32'd3);
        wr(8'h00, 32'h3);
        rd(8'h14, v); chk("R4 start", v, 3);
        @(negedge clk); rd(8'h14, v); chk("R4 step 2", v, 2);
        @(negedge clk); rd(8'h14, v); chk("R4 step 1", v, 1);
        @(negedge clk); rd(8'h14, v); chk("R4 step 0", v, 0);
        rd(8'h04, v); chk("R4 no flag yet", v, 0);
        @(negedge clk); rd(8'h14, v); chk("R4 reloaded", v, 3);
        rd(8'h04, v); chk("R4 flag on reload", v, 1);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'h0);
        wr(8'h00, 32'h3);
        @(negedge clk); rd(8'h14, v); chk("R5 wrap to all ones", v, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R5 flag on wrap", v, 1);
        @(negedge clk); rd(8'h14, v); chk("R5 keeps counting", v, 32'hFFFF_FFFE);
    endtask

    task automatic t_status_b();
        logic [31:0] v;
        wr(8'h1C, 32'd2);
        wr(8'h00, 32'h4);
        repeat (5) @(negedge clk);
        rd(8'h04, v); chk("R6 both flags", v, 32'h101);
        chk("R7 irq only for running timer", 32'(irq), 32'h2);
        wr(8'h04, 32'hFFFF_FEFF);
        rd(8'h04, v); chk("R6 clear only B", v, 32'h001);
        wr(8'h04, 32'hFFFF_FFFE);
        rd(8'h04, v); chk("R6 clear A", v, 0);
    endtask

    task automatic t_freeze();
        logic [31:0] v, w;
        wr(8'h10, 32'd100); wr(8'h14, 32'd100);
        wr(8'h00, 32'h3);
        repeat (10) @(negedge clk);
        wr(8'h00, 32'h0);
        rd(8'h14, v);
        repeat (6) @(negedge clk);
        rd(8'h14, w); chk("R8 value kept while stopped", w, v);
        chk("R8 value moved before stop", 32'(v < 100), 1);
    endtask

    task automatic t_fixed();
        logic [31:0] v;
        wr(8'h1C, 32'd10);
        wr(8'h00, 32'h0000_1004);
        repeat (5) @(negedge clk);
        rd(8'h1C, v); chk("R9 no tick no count", v, 10);
        fixed_tick = 1'b1;
        repeat (3) @(negedge clk);
        fixed_tick = 1'b0;
        rd(8'h1C, v); chk("R9 three fixed ticks", v, 7);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_prescale(input int n);
        logic [31:0] v, last;
        int chg [3];
        int k = 0;
        wr(8'h18, 32'd1); wr(8'h1C, 32'd1);
        wr(8'h00, 32'hC | (32'(n) << 22));
        rd(8'h1C, last);
        for (int c = 0; c < 400 && k < 3; c++) begin
            @(negedge clk);
            rd(8'h1C, v);
            if (v != last) begin chg[k] = c; k++; end
            last = v;
        end
        chk("R10 changes seen", 32'(k), 3);
        chk("R10 interval 2^N first", 32'(chg[1] - chg[0]), 32'(1 << n));
        chk("R10 interval 2^N second", 32'(chg[2] - chg[1]), 32'(1 << n));
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(8'h00, 32'h0000_0801);
        wr(8'h14, 32'h0);
        wr(8'h04, 32'h0);
        @(negedge clk);
        bus_addr = 8'h14; bus_we = 1'b1; bus_wdata = 32'd7; fixed_tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; fixed_tick = 1'b0;
        rd(8'h14, v); chk("R11 write beats tick", v, 7);
        rd(8'h04, v); chk("R11 no flag from collided tick", v, 0);
        wr(8'h14, 32'h0);
        @(negedge clk); fixed_tick = 1'b1;
        @(negedge clk); fixed_tick = 1'b0;
        rd(8'h04, v); chk("R12 flag set before collision", v, 1);
        wr(8'h14, 32'h0);
        @(negedge clk);
        bus_addr = 8'h04; bus_we = 1'b1; bus_wdata = 32'hFFFF_FFFE; fixed_tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; fixed_tick = 1'b0;
        rd(8'h04, v); chk("R12 expiry beats clear", v, 1);
        wr(8'h04, 32'hFFFF_FFFE);
        rd(8'h04, v); chk("R6 plain clear", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        wr(8'h10, 32'h0); wr(8'h18, 32'h0);
        t_oneshot();
        t_periodic();
        t_wrap();
        t_status_b();
        t_freeze();
        t_fixed();
        t_prescale(2);
        t_prescale(5);
        t_collide();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule